// File: doc/BRIEF.md
# Overflow-Interrupting Event Counter Bank

A bank of programmable event counters numbered 3 through 31. Every counter owns a wide count register and a 64-bit control word. The low part of the control word picks one of a small set of event inputs. The top six bits hold a sticky overflow flag and five inhibit bits, one for each privilege mode. A counter adds one for each cycle in which its selected event input is high, unless a shared inhibit mask freezes it or the hart runs in a mode the counter is told to ignore.

When a count wraps from all ones to zero, the counter sets its overflow flag. If the flag was clear before the wrap, the counter also latches a pending count-overflow request. The bank ORs these requests into one interrupt line, which stands for local interrupt 13. A read-only summary register gathers the overflow flags. Each flag in it is gated by a per-counter access enable, so a lower privilege level can see which counters wrapped without reading every control word. All registers sit behind a simple single-cycle CSR port: a registered write and a combinational read.

Top module: `ovf_counter_bank`

## Requirements
- R1: Counter i (3..31) increments by one in each cycle in which event input `evt_i[s]` is high, where s is the selector held in control bits [57:0]. A selector of NUM_EVT or above never counts. Count register i is at CSR address 0xB00+i and control word i is at 0x320+i.
- R2: The shared inhibit mask at CSR 0x320 freezes counter i for as long as bit i is set. Counters whose mask bit is clear keep counting in the same cycle.
- R3: Control bits 62, 61, 60, 59 and 58 stop counting in mode M, S, U, VS and VU. The mode comes from `priv_i` (0 = U, 1 = S, 3 = M) and `virt_i`: virt with S gives VS, virt with U gives VU, and virt is ignored in M.
- R4: An increment from all ones wraps the count to zero and sets the overflow flag, control bit 63, visible from the next cycle.
- R5: A wrap while bit 63 is 0 raises `irq_o` from the next cycle. A wrap while bit 63 is already 1 raises no request.
- R6: Bit 63 stays set through later counting and through clearing of the pending interrupt, until software writes it to 0.
- R7: A counter's pending request clears when software writes its control word with bit 63 = 0. All pending requests clear when software writes the pending CSR (0x344) with bit 13 = 0.
- R8: The summary CSR at 0xDA0 reads bit i (3..31) as counter i's bit 63 ANDed with bit i of the access-enable CSR at 0x306. Bits 0..2 and 32..63 read 0.
- R9: A CSR write to a count register in the same cycle as an increment of that counter loads the written value, and the increment is lost.
- R10: After reset, every count, control word, mask and pending request is zero, so `irq_o` is low.
- R11: Reading the pending CSR 0x344 returns `irq_o` at bit 13 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_EVT | Event pulses, one per selectable source |
| priv_i | input | 2 | Current privilege level (0 U, 1 S, 3 M) |
| virt_i | input | 1 | Hart runs virtualized |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address for reads and writes |
| csr_wdata_i | input | 64 | CSR write data |
| csr_rdata_o | output | 64 | CSR read data, combinational from address |
| irq_o | output | 1 | Count-overflow interrupt request (local interrupt 13) |

## Verification
The bench builds the bank with CNT_W = 8 and NUM_EVT = 4, and keeps the full range of counters 3..31. The narrow counter brings the wrap from all ones to zero within a few event pulses once the count is preloaded. The four event inputs let a selector past the last input (9) be tried as a no-count case. Every counter stays live, so the summary gating and the shared inhibit mask are seen across several counters and not only one.

// File: rtl/ocb_pkg.sv
package ocb_pkg;
  // control word field positions (descending: flag, then M, S, U, VS, VU)
  localparam int CTL_OF    = 63;
  localparam int CTL_MINH  = 62;
  localparam int CTL_VUINH = 58;
  localparam int SEL_TOP   = 57;

  localparam logic [11:0] A_CNT_BASE = 12'hB00;
  localparam logic [11:0] A_CTL_BASE = 12'h320;
  localparam logic [11:0] A_INHIBIT  = 12'h320;
  localparam logic [11:0] A_ENABLE   = 12'h306;
  localparam logic [11:0] A_SUMMARY  = 12'hDA0;
  localparam logic [11:0] A_PEND     = 12'h344;
  localparam int          IRQ_BIT    = 13;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  // one-hot mode vector order matches control bits 62..58
  typedef struct packed {
    logic m;
    logic s;
    logic u;
    logic vs;
    logic vu;
  } mode_oh_t;
endpackage

// File: rtl/ocb_mode_dec.sv
module ocb_mode_dec
  import ocb_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  output mode_oh_t   mode_o
);
  priv_e priv;

  always_comb begin
    priv    = priv_e'(priv_i);
    mode_o  = '0;
    unique case (priv)
      PRIV_M:   mode_o.m  = 1'b1;
      PRIV_S:   begin
                  mode_o.s  = ~virt_i;
                  mode_o.vs = virt_i;
                end
      PRIV_U:   begin
                  mode_o.u  = ~virt_i;
                  mode_o.vu = virt_i;
                end
      default:  mode_o = '0;
    endcase
  end
endmodule

// File: rtl/ocb_counter.sv
module ocb_counter
  import ocb_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  mode_oh_t           mode_i,
  input  logic               gl_inh_i,
  input  logic               cnt_we_i,
  input  logic               ctl_we_i,
  input  logic               pend_clr_i,
  input  logic [63:0]        wdata_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [63:0]        ctl_o,
  output logic               of_o,
  output logic               pend_o
);
  localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [62:0]      cfg_q;
  logic             of_q, of_d;
  logic             pend_q, pend_d;
  logic             sel_ok, evt_hit, mode_inh, inc, ovf;
  logic             cnt_en, of_en, pend_en;

  always_comb begin
    sel_ok   = cfg_q[SEL_TOP:0] < 58'(NUM_EVT);
    evt_hit  = sel_ok && evt_i[cfg_q[SEL_W-1:0]];
    mode_inh = |(cfg_q[CTL_MINH:CTL_VUINH] & mode_i);
    inc      = evt_hit & ~gl_inh_i & ~mode_inh;
    ovf      = inc & ~cnt_we_i & (&cnt_q);
  end

  always_comb begin
    cnt_en = cnt_we_i | inc;
    cnt_d  = cnt_we_i ? wdata_i[CNT_W-1:0] : cnt_q + 1'b1;

    of_en  = ctl_we_i | ovf;
    of_d   = (ctl_we_i ? wdata_i[CTL_OF] : of_q) | ovf;

    pend_en = pend_clr_i | ctl_we_i | ovf;
    pend_d  = pend_q;
    if (pend_clr_i || (ctl_we_i && !wdata_i[CTL_OF])) pend_d = 1'b0;
    if (ovf && !of_q)                                 pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cfg_q  <= '0;
      of_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (cnt_en)   cnt_q  <= cnt_d;
      if (ctl_we_i) cfg_q  <= wdata_i[62:0];
      if (of_en)    of_q   <= of_d;
      if (pend_en)  pend_q <= pend_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign ctl_o  = {of_q, cfg_q};
  assign of_o   = of_q;
  assign pend_o = pend_q;

  // R2: a frozen counter with no software write keeps its value
  p_inhibit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gl_inh_i && !cnt_we_i) |=> $stable(cnt_q));

  // R4: a wrap leaves zero count and the flag set
  p_wrap_sets_of_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && !gl_inh_i && !mode_inh && !cnt_we_i && (&cnt_q)) |=> (of_q && cnt_q == '0));

  // R5: with the flag already set, no new request appears
  p_no_req_when_of_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (of_q && !pend_q && !ctl_we_i) |=> !pend_q);

  // R6: the flag is only cleared by a control write
  p_of_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (of_q && !ctl_we_i) |=> of_q);

  // R9: a count write wins over a coincident increment
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i |=> (cnt_q == $past(wdata_i[CNT_W-1:0])));
endmodule

// File: rtl/ocb_rd_mux.sv
module ocb_rd_mux
  import ocb_pkg::*;
#(
  parameter int FIRST_CTR = 3,
  parameter int LAST_CTR  = 31,
  parameter int CNT_W     = 64
) (
  input  logic [11:0]                                      addr_i,
  input  logic [LAST_CTR-FIRST_CTR:0][CNT_W-1:0]           cnt_i,
  input  logic [LAST_CTR-FIRST_CTR:0][63:0]                ctl_i,
  input  logic [31:0]                                      inh_i,
  input  logic [31:0]                                      en_i,
  input  logic [31:0]                                      summary_i,
  input  logic                                             irq_i,
  output logic [63:0]                                      rdata_o
);
  localparam int NUM_CTR = LAST_CTR - FIRST_CTR + 1;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_INHIBIT) rdata_o[31:0] = inh_i;
    if (addr_i == A_ENABLE)  rdata_o[31:0] = en_i;
    if (addr_i == A_SUMMARY) rdata_o[31:0] = summary_i;
    if (addr_i == A_PEND)    rdata_o[IRQ_BIT] = irq_i;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (addr_i == A_CNT_BASE + 12'(FIRST_CTR + k)) rdata_o[CNT_W-1:0] = cnt_i[k];
      if (addr_i == A_CTL_BASE + 12'(FIRST_CTR + k)) rdata_o = ctl_i[k];
    end
  end
endmodule

// File: rtl/ovf_counter_bank.sv
module ovf_counter_bank
  import ocb_pkg::*;
#(
  parameter int FIRST_CTR = 3,
  parameter int LAST_CTR  = 31,
  parameter int CNT_W     = 64,
  parameter int NUM_EVT   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               csr_we_i,
  input  logic [11:0]        csr_addr_i,
  input  logic [63:0]        csr_wdata_i,
  output logic [63:0]        csr_rdata_o,
  output logic               irq_o
);
  localparam int NUM_CTR = LAST_CTR - FIRST_CTR + 1;

  mode_oh_t                         mode;
  logic [31:0]                      inh_q, inh_d, en_q, en_d, summary;
  logic                             inh_we, en_we, pend_clr;
  logic [NUM_CTR-1:0][CNT_W-1:0]    cnt_all;
  logic [NUM_CTR-1:0][63:0]         ctl_all;
  logic [NUM_CTR-1:0]               of_all, pend_all;

  ocb_mode_dec i_mode_dec (
    .priv_i (priv_i),
    .virt_i (virt_i),
    .mode_o (mode)
  );

  always_comb begin
    inh_we   = csr_we_i && (csr_addr_i == A_INHIBIT);
    en_we    = csr_we_i && (csr_addr_i == A_ENABLE);
    pend_clr = csr_we_i && (csr_addr_i == A_PEND) && !csr_wdata_i[IRQ_BIT];
    inh_d    = csr_wdata_i[31:0];
    en_d     = csr_wdata_i[31:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q <= '0;
      en_q  <= '0;
    end else begin
      if (inh_we) inh_q <= inh_d;
      if (en_we)  en_q  <= en_d;
    end
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    logic cnt_we, ctl_we;
    assign cnt_we = csr_we_i && (csr_addr_i == A_CNT_BASE + 12'(FIRST_CTR + g));
    assign ctl_we = csr_we_i && (csr_addr_i == A_CTL_BASE + 12'(FIRST_CTR + g));

    ocb_counter #(
      .CNT_W   (CNT_W),
      .NUM_EVT (NUM_EVT)
    ) i_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i),
      .mode_i     (mode),
      .gl_inh_i   (inh_q[FIRST_CTR + g]),
      .cnt_we_i   (cnt_we),
      .ctl_we_i   (ctl_we),
      .pend_clr_i (pend_clr),
      .wdata_i    (csr_wdata_i),
      .cnt_o      (cnt_all[g]),
      .ctl_o      (ctl_all[g]),
      .of_o       (of_all[g]),
      .pend_o     (pend_all[g])
    );
  end

  always_comb begin
    summary = '0;
    for (int k = 0; k < NUM_CTR; k++) summary[FIRST_CTR + k] = of_all[k] & en_q[FIRST_CTR + k];
  end

  assign irq_o = |pend_all;

  ocb_rd_mux #(
    .FIRST_CTR (FIRST_CTR),
    .LAST_CTR  (LAST_CTR),
    .CNT_W     (CNT_W)
  ) i_rd_mux (
    .addr_i    (csr_addr_i),
    .cnt_i     (cnt_all),
    .ctl_i     (ctl_all),
    .inh_i     (inh_q),
    .en_i      (en_q),
    .summary_i (summary),
    .irq_i     (irq_o),
    .rdata_o   (csr_rdata_o)
  );

  // R7: a pending-CSR clear leaves no request in the next cycle
  p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !(|(of_all & ~of_all))) |=> (!irq_o || $rose(irq_o)));

  // R10: nothing is pending right after reset release
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_o);
endmodule

// File: tb/test_ovf_counter_bank.sv
module test_ovf_counter_bank;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int NUM_EVT    = 4;
  localparam int WD_CYC     = 20000;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_EVT-1:0] evt = '0;
  logic [1:0]         priv = 2'd3;
  logic               virt = 1'b0;
  logic               csr_we = 1'b0;
  logic [11:0]        csr_addr = '0;
  logic [63:0]        csr_wdata = '0;
  logic [63:0]        csr_rdata;
  logic               irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  ovf_counter_bank #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) i_ovf_counter_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt),
    .priv_i      (priv),
    .virt_i      (virt),
    .csr_we_i    (csr_we),
    .csr_addr_i  (csr_addr),
    .csr_wdata_i (csr_wdata),
    .csr_rdata_o (csr_rdata),
    .irq_o       (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_CYC && !done) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  task automatic pulse(input logic [NUM_EVT-1:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt = m;
      @(negedge clk); evt = '0;
    end
  endtask

  function automatic logic [11:0] cnt_a(input int i); return 12'hB00 + 12'(i); endfunction
  function automatic logic [11:0] ctl_a(input int i); return 12'h320 + 12'(i); endfunction

  task automatic t_reset;
    logic [63:0] v;
    rd(cnt_a(3), v);  chk("R10 count3", v, 0);
    rd(ctl_a(3), v);  chk("R10 ctl3", v, 0);
    rd(12'hDA0, v);   chk("R10 summary", v, 0);
    rd(12'h344, v);   chk("R11 pending csr", v, 0);
    chk("R10 irq", irq, 0);
  endtask

  task automatic t_count_basic;
    logic [63:0] v;
    wr(cnt_a(3), 0);
    pulse(4'h1, 5);
    rd(cnt_a(3), v); chk("R1 ctr3 sel0", v, 5);
    wr(ctl_a(4), 2); wr(cnt_a(4), 0);
    pulse(4'h4, 3); pulse(4'h1, 2);
    rd(cnt_a(4), v); chk("R1 ctr4 sel2", v, 3);
    rd(cnt_a(3), v); chk("R1 ctr3 ignores evt2", v, 7);
    wr(ctl_a(9), 9); wr(cnt_a(9), 0);
    pulse(4'hF, 1);
    rd(cnt_a(9), v); chk("R1 out-of-range selector", v, 0);
  endtask

  task automatic t_global_inhibit;
    logic [63:0] v;
    wr(cnt_a(3), 8); wr(cnt_a(7), 0);
    wr(12'h320, 64'h8);
    pulse(4'h1, 1);
    rd(cnt_a(3), v); chk("R2 ctr3 frozen", v, 8);
    rd(cnt_a(7), v); chk("R2 ctr7 counts", v, 1);
    wr(12'h320, 0);
    pulse(4'h1, 1);
    rd(cnt_a(3), v); chk("R2 ctr3 resumes", v, 9);
  endtask

  task automatic t_mode_inhibit;
    logic [63:0] v;
    wr(ctl_a(5), (64'd1 << 61) | 1); wr(cnt_a(5), 0);
    priv = 2'd1; virt = 1'b0; pulse(4'h2, 1);
    rd(cnt_a(5), v); chk("R3 S inhibited", v, 0);
    priv = 2'd0; pulse(4'h2, 1);
    rd(cnt_a(5), v); chk("R3 U counts", v, 1);
    wr(ctl_a(5), (64'd1 << 58) | 1);
    virt = 1'b1; pulse(4'h2, 1);
    rd(cnt_a(5), v); chk("R3 VU inhibited", v, 1);
    priv = 2'd1; pulse(4'h2, 1);
    rd(cnt_a(5), v); chk("R3 VS counts", v, 2);
    wr(ctl_a(5), (64'd1 << 62) | 1);
    priv = 2'd3; pulse(4'h2, 1);
    rd(cnt_a(5), v); chk("R3 M inhibited", v, 2);
    priv = 2'd0; virt = 1'b0; pulse(4'h2, 1);
    rd(cnt_a(5), v); chk("R3 U counts under MINH", v, 3);
    priv = 2'd3;
  endtask

  task automatic t_overflow;
    logic [63:0] v;
    wr(ctl_a(6), 3); wr(cnt_a(6), 8'hFE);
    pulse(4'h8, 1);
    rd(ctl_a(6), v); chk("R4 no flag at all-ones", v, 3);
    chk("R5 no irq before wrap", irq, 0);
    pulse(4'h8, 1);
    rd(cnt_a(6), v); chk("R4 wrapped to zero", v, 0);
    rd(ctl_a(6), v); chk("R4 flag set", v, 64'h8000_0000_0000_0003);
    chk("R5 irq raised", irq, 1);
    rd(12'h344, v); chk("R11 pending bit13", v, 64'h2000);
  endtask

  task automatic t_sticky;
    logic [63:0] v;
    pulse(4'h8, 2);
    rd(cnt_a(6), v); chk("R6 count continues", v, 2);
    rd(ctl_a(6), v); chk("R6 flag held", v[63], 1);
    chk("R6 irq held", irq, 1);
  endtask

  task automatic t_irq_clear;
    logic [63:0] v;
    wr(ctl_a(6), 3);
    chk("R7 irq cleared by flag write", irq, 0);
    rd(ctl_a(6), v); chk("R7 flag cleared", v, 3);
    wr(cnt_a(6), 8'hFF);
    pulse(4'h8, 1);
    chk("R5 irq on second wrap", irq, 1);
    wr(12'h344, 64'h2000);
    chk("R7 write of bit13=1 keeps irq", irq, 1);
    wr(12'h344, 0);
    chk("R7 irq cleared by pending write", irq, 0);
    rd(ctl_a(6), v); chk("R6 flag survives pending clear", v[63], 1);
  endtask

  task automatic t_of_disable;
    logic [63:0] v;
    wr(ctl_a(8), (64'd1 << 63) | 3); wr(cnt_a(8), 8'hFF);
    pulse(4'h8, 1);
    rd(cnt_a(8), v); chk("R4 ctr8 wrapped", v, 0);
    chk("R5 flag set masks request", irq, 0);
  endtask

  task automatic t_summary;
    logic [63:0] v;
    wr(12'h306, 0);
    rd(12'hDA0, v); chk("R8 all gated", v, 0);
    wr(12'h306, 64'h40);
    rd(12'hDA0, v); chk("R8 only ctr6", v, 64'h40);
    wr(12'h306, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'hDA0, v); chk("R8 ctr6 and ctr8", v, 64'h140);
  endtask

  task automatic t_write_priority;
    logic [63:0] v;
    wr(cnt_a(7), 0);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = cnt_a(3); csr_wdata = 64'h40; evt = 4'h1;
    @(negedge clk);
    csr_we = 1'b0; evt = '0;
    rd(cnt_a(3), v); chk("R9 write beats increment", v, 64'h40);
    rd(cnt_a(7), v); chk("R9 neighbour still counts", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_basic();
    t_global_inhibit();
    t_mode_inhibit();
    t_overflow();
    t_sticky();
    t_irq_clear();
    t_of_disable();
    t_summary();
    t_write_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule